// File: doc/BRIEF.md
# Reconfigurable Switch Element Grid

A rectangular grid of two-state switch elements that steers cells between row inputs arriving from the west and column inputs arriving from the north. Each element receives one cell from the west and one from the north. It either passes both straight through (cross) or exchanges them (toggle). Cells leaving the east edge are discarded cells. Cells leaving the south edge go to the output links. A cell is modelled only by its tags: a valid bit, an address field and a priority field.

In normal operation each element compares the tags of the two cells it receives. Per-element control bits can override that comparison. Force bits drive an element to cross or to toggle for test patterns and for reconfiguration. Fault bits make an element behave as stuck in one state, so that diagnosis procedures can be run against a known defect. A stuck-toggle element can be neutralised while the grid is running by setting its force-cross bit. All routing is combinational, and the grid's edge outputs are registered.

Top module: `swe_grid`

## Requirements
- R1: In the cross state an element passes its west cell out on its east side and its north cell out on its south side. With every force-cross bit set, east output i carries west input i and south output j carries north input j.
- R2: In the toggle state an element passes its west cell out on its south side and its north cell out on its east side.
- R3: With no override active, an element crosses when its two cells carry different address fields.
- R4: With no override active and equal address fields, an element toggles only when both cells are valid and the west priority is strictly greater than the north priority. Equal priorities, or any invalid cell, give cross.
- R5: Control precedence per element, highest first: stuck-cross fault, force-cross, stuck-toggle fault, force-toggle, then the normal comparison. Control bit index k is row*COLS + column.
- R6: Take a stuck-toggle fault at (i,j) with force-cross set on every other element. South output j then carries west input i, east output i carries north input j, and every other output passes straight through.
- R7: An element with both a stuck-toggle fault and force-cross set produces the same outputs as the same element with a stuck-cross fault, for the same inputs and the same other settings.
- R8: A square sub-block can be forced to toggle while all other elements are forced to cross. The outputs then follow R1 and R2 for that state map.
- R9: The outputs present the routing of the inputs sampled at the previous rising clock edge and hold steady between edges. During reset all output valid bits are 0.
- R10: The number of valid output cells equals the number of valid input cells of the previous cycle.
- R11: The priority field is PW bits wide, with PW=4 by default, one bit beyond a 3-bit normal field. Comparison uses all PW bits, so priority 8 beats priority 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| west_vld | input | ROWS | Valid bit of each row input cell |
| west_addr | input | ROWS*AW | Address field of each row input, row i at bits i*AW |
| west_pri | input | ROWS*PW | Priority field of each row input, row i at bits i*PW |
| north_vld | input | COLS | Valid bit of each column input cell |
| north_addr | input | COLS*AW | Address field of each column input |
| north_pri | input | COLS*PW | Priority field of each column input |
| force_cross | input | ROWS*COLS | Per-element force-cross bits |
| force_toggle | input | ROWS*COLS | Per-element force-toggle bits |
| stuck_cross | input | ROWS*COLS | Per-element injected stuck-cross fault |
| stuck_toggle | input | ROWS*COLS | Per-element injected stuck-toggle fault |
| east_vld | output | ROWS | Valid bits of discard outputs |
| east_addr | output | ROWS*AW | Address fields of discard outputs |
| east_pri | output | ROWS*PW | Priority fields of discard outputs |
| south_vld | output | COLS | Valid bits of output links |
| south_addr | output | COLS*AW | Address fields of output links |
| south_pri | output | COLS*PW | Priority fields of output links |

## Verification
Every routed result appears at the outputs exactly one rising edge after its inputs and controls are presented. The bench therefore drives on a falling edge and samples on the next falling edge, after a single register stage. One check samples a quarter period after a new drive, before any edge, and confirms that the old result is still held. The reset check samples while reset is held and looks only for cleared valid bits.

// File: rtl/swe_grid.sv
module swe_grid #(
  parameter int ROWS = 4,
  parameter int COLS = 4,
  parameter int AW   = 2,
  parameter int PW   = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ROWS-1:0]      west_vld,
  input  logic [ROWS*AW-1:0]   west_addr,
  input  logic [ROWS*PW-1:0]   west_pri,
  input  logic [COLS-1:0]      north_vld,
  input  logic [COLS*AW-1:0]   north_addr,
  input  logic [COLS*PW-1:0]   north_pri,
  input  logic [ROWS*COLS-1:0] force_cross,
  input  logic [ROWS*COLS-1:0] force_toggle,
  input  logic [ROWS*COLS-1:0] stuck_cross,
  input  logic [ROWS*COLS-1:0] stuck_toggle,
  output logic [ROWS-1:0]      east_vld,
  output logic [ROWS*AW-1:0]   east_addr,
  output logic [ROWS*PW-1:0]   east_pri,
  output logic [COLS-1:0]      south_vld,
  output logic [COLS*AW-1:0]   south_addr,
  output logic [COLS*PW-1:0]   south_pri
);
  localparam int CW = 1 + AW + PW;
  localparam int N  = ROWS * COLS;

  logic [CW-1:0] hc [ROWS][COLS+1];
  logic [CW-1:0] vc [ROWS+1][COLS];
  logic [CW-1:0] east_q  [ROWS];
  logic [CW-1:0] south_q [COLS];

  genvar i, j;
  generate
    for (i = 0; i < ROWS; i++) begin : g_win
      assign hc[i][0] = {west_vld[i], west_addr[i*AW +: AW], west_pri[i*PW +: PW]};
    end
    for (j = 0; j < COLS; j++) begin : g_nin
      assign vc[0][j] = {north_vld[j], north_addr[j*AW +: AW], north_pri[j*PW +: PW]};
    end

    for (i = 0; i < ROWS; i++) begin : g_row
      for (j = 0; j < COLS; j++) begin : g_col
        localparam int K = i * COLS + j;
        wire [CW-1:0] wc = hc[i][j];
        wire [CW-1:0] nc = vc[i][j];
        wire same_addr = wc[CW-2 -: AW] == nc[CW-2 -: AW];
        wire cmp_tog = wc[CW-1] & nc[CW-1] & same_addr & (wc[PW-1:0] > nc[PW-1:0]);
        wire tog = stuck_cross[K]  ? 1'b0 :
                   force_cross[K]  ? 1'b0 :
                   stuck_toggle[K] ? 1'b1 :
                   force_toggle[K] ? 1'b1 : cmp_tog;
        assign hc[i][j+1] = tog ? nc : wc;
        assign vc[i+1][j] = tog ? wc : nc;
      end
    end

    for (i = 0; i < ROWS; i++) begin : g_eout
      always_ff @(posedge clk) begin
        if (!rst_n) east_q[i] <= '0;
        else        east_q[i] <= hc[i][COLS];
      end
      assign east_vld[i]            = east_q[i][CW-1];
      assign east_addr[i*AW +: AW]  = east_q[i][CW-2 -: AW];
      assign east_pri[i*PW +: PW]   = east_q[i][PW-1:0];
    end
    for (j = 0; j < COLS; j++) begin : g_sout
      always_ff @(posedge clk) begin
        if (!rst_n) south_q[j] <= '0;
        else        south_q[j] <= vc[ROWS][j];
      end
      assign south_vld[j]           = south_q[j][CW-1];
      assign south_addr[j*AW +: AW] = south_q[j][CW-2 -: AW];
      assign south_pri[j*PW +: PW]  = south_q[j][PW-1:0];
    end

    // R6
    for (i = 0; i < ROWS; i++) begin : g_diag_r
      for (j = 0; j < COLS; j++) begin : g_diag_c
        localparam logic [N-1:0] BIT = {{(N-1){1'b0}}, 1'b1} << (i * COLS + j);
        ts_locate_chk: assert property (@(posedge clk) disable iff (!rst_n)
          $past(rst_n && stuck_toggle == BIT && force_cross == ~BIT && (stuck_cross & BIT) == '0)
          |-> (south_q[j] == $past(hc[i][0]) && east_q[i] == $past(vc[0][j])));
      end
    end
  endgenerate

  // R10
  cell_conserve_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ($countones({east_vld, south_vld}) == $past($countones({west_vld, north_vld}))));

  // R1
  all_cross_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n && (&force_cross)) |->
      (east_vld == $past(west_vld) && east_addr == $past(west_addr) && east_pri == $past(west_pri) &&
       south_vld == $past(north_vld) && south_addr == $past(north_addr) && south_pri == $past(north_pri)));

  // R9
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (east_vld == '0 && south_vld == '0));
endmodule

// File: tb/swe_grid_tb.sv
module swe_grid_tb;
  localparam int ROWS = 4, COLS = 4, AW = 2, PW = 4;
  localparam int CW = 1 + AW + PW, N = ROWS * COLS;

  logic clk = 0, rst_n = 0;
  logic [ROWS-1:0] wv, ev;  logic [ROWS*AW-1:0] wa, ea;  logic [ROWS*PW-1:0] wp, ep;
  logic [COLS-1:0] nv, sv;  logic [COLS*AW-1:0] na, sa;  logic [COLS*PW-1:0] np, sp;
  logic [N-1:0] fc, ft, sc, st;
  int tests = 0, fails = 0;
  logic [CW-1:0] exp_e [ROWS];
  logic [CW-1:0] exp_s [COLS];
  logic [CW-1:0] sav_e [ROWS];
  logic [CW-1:0] sav_s [COLS];

  always #10 clk = ~clk;

  swe_grid #(.ROWS(ROWS), .COLS(COLS), .AW(AW), .PW(PW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .west_vld(wv), .west_addr(wa), .west_pri(wp),
    .north_vld(nv), .north_addr(na), .north_pri(np),
    .force_cross(fc), .force_toggle(ft), .stuck_cross(sc), .stuck_toggle(st),
    .east_vld(ev), .east_addr(ea), .east_pri(ep),
    .south_vld(sv), .south_addr(sa), .south_pri(sp));

  function automatic logic [CW-1:0] win(int i);  return {wv[i], wa[i*AW +: AW], wp[i*PW +: PW]}; endfunction
  function automatic logic [CW-1:0] nin(int j);  return {nv[j], na[j*AW +: AW], np[j*PW +: PW]}; endfunction
  function automatic logic [CW-1:0] eout(int i); return {ev[i], ea[i*AW +: AW], ep[i*PW +: PW]}; endfunction
  function automatic logic [CW-1:0] sout(int j); return {sv[j], sa[j*AW +: AW], sp[j*PW +: PW]}; endfunction

  task automatic set_w(int i, logic v, int a, int p);
    wv[i] = v; wa[i*AW +: AW] = AW'(a); wp[i*PW +: PW] = PW'(p);
  endtask
  task automatic set_n(int j, logic v, int a, int p);
    nv[j] = v; na[j*AW +: AW] = AW'(a); np[j*PW +: PW] = PW'(p);
  endtask
  task automatic rand_in();
    wv = ROWS'($urandom); wa = ROWS*AW'($urandom); wp = ROWS*PW'($urandom);
    nv = COLS'($urandom); na = COLS*AW'($urandom); np = COLS*PW'($urandom);
  endtask

  // expected outputs for a given state map (1 = toggle), walking cells through the grid
  task automatic route(logic [N-1:0] tmap);
    logic [CW-1:0] h [ROWS];
    logic [CW-1:0] v [COLS];
    logic [CW-1:0] t;
    for (int i = 0; i < ROWS; i++) h[i] = win(i);
    for (int j = 0; j < COLS; j++) v[j] = nin(j);
    for (int i = 0; i < ROWS; i++)
      for (int j = 0; j < COLS; j++)
        if (tmap[i*COLS+j]) begin t = h[i]; h[i] = v[j]; v[j] = t; end
    for (int i = 0; i < ROWS; i++) exp_e[i] = h[i];
    for (int j = 0; j < COLS; j++) exp_s[j] = v[j];
  endtask

  task automatic step(); @(negedge clk); endtask

  task automatic check_all(string tag);
    bit bad = 0;
    tests++;
    for (int i = 0; i < ROWS; i++)
      if (!bad && eout(i) !== exp_e[i]) begin
        bad = 1; $display("FAIL %s east[%0d] actual=%h expected=%h", tag, i, eout(i), exp_e[i]);
      end
    for (int j = 0; j < COLS; j++)
      if (!bad && sout(j) !== exp_s[j]) begin
        bad = 1; $display("FAIL %s south[%0d] actual=%h expected=%h", tag, j, sout(j), exp_s[j]);
      end
    if (bad) fails++;
  endtask

  task automatic check_int(string tag, int act, int exp);
    tests++;
    if (act !== exp) begin fails++; $display("FAIL %s actual=%0d expected=%0d", tag, act, exp); end
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [N-1:0] bitk, blk, tmap;
    int cnt;
    wv = '1; wa = '1; wp = '1; nv = '1; na = '1; np = '1;
    fc = '0; ft = '0; sc = '0; st = '0;
    repeat (3) step();
    // R9: cleared while reset held
    check_int("R9 reset valid", int'({ev, sv}), 0);
    rst_n = 1;

    // R1: all forced cross
    fc = '1;
    for (int n = 0; n < 20; n++) begin
      rand_in(); route('0); step(); check_all("R1 all cross");
    end

    // R2: all forced toggle
    fc = '0; ft = '1;
    for (int n = 0; n < 20; n++) begin
      rand_in(); route('1); step(); check_all("R2 all toggle");
    end

    // R9: result held until the next edge, then updated
    fc = '1; ft = '0; rand_in(); route('0); step();
    for (int i = 0; i < ROWS; i++) sav_e[i] = exp_e[i];
    for (int j = 0; j < COLS; j++) sav_s[j] = exp_s[j];
    rand_in(); #5;
    for (int i = 0; i < ROWS; i++) exp_e[i] = sav_e[i];
    for (int j = 0; j < COLS; j++) exp_s[j] = sav_s[j];
    check_all("R9 hold before edge");
    route('0); step(); check_all("R9 one cycle latency");

    // R3 R4 R11: normal comparison on element 0, all others forced cross
    fc = ~N'(1); ft = '0; sc = '0; st = '0;
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++)
        for (int p = 0; p < 16; p += 5)
          for (int q = 0; q < 16; q += 5) begin
            rand_in(); set_w(0, 1, a, p); set_n(0, 1, b, q);
            tmap = '0; tmap[0] = (a == b) && (p > q);
            route(tmap); step();
            check_all((a == b) ? "R4 equal addr compare" : "R3 diff addr cross");
          end
    rand_in(); set_w(0, 1, 2, 9); set_n(0, 0, 2, 1); route('0); step(); check_all("R4 invalid north cross");
    rand_in(); set_w(0, 0, 2, 9); set_n(0, 1, 2, 1); route('0); step(); check_all("R4 invalid west cross");
    rand_in(); set_w(0, 1, 1, 8); set_n(0, 1, 1, 7); route(N'(1)); step(); check_all("R11 top bit 8>7");
    rand_in(); set_w(0, 1, 1, 7); set_n(0, 1, 1, 8); route('0); step(); check_all("R11 top bit 7<8");
    rand_in(); set_w(0, 1, 3, 6); set_n(0, 1, 3, 6); route('0); step(); check_all("R4 equal priority cross");

    // R5: precedence on element (1,2), k=6
    bitk = N'(1) << 6;
    for (int m = 0; m < 2; m++)
      for (int c = 0; c < 16; c++) begin
        bit cmp, t;
        rand_in(); set_w(1, 1, 1, 9); set_n(2, 1, (m == 0) ? 1 : 2, 3);
        cmp = (m == 0);
        sc = c[3] ? bitk : '0;
        fc = ~bitk | (c[2] ? bitk : '0);
        st = c[1] ? bitk : '0;
        ft = c[0] ? bitk : '0;
        t = c[3] ? 0 : c[2] ? 0 : c[1] ? 1 : c[0] ? 1 : cmp;
        tmap = t ? bitk : '0;
        route(tmap); step(); check_all("R5 precedence");
      end

    // R6: locating a stuck-toggle element
    sc = '0; ft = '0;
    for (int k = 0; k < N; k++) begin
      bitk = N'(1) << k;
      st = bitk; fc = ~bitk; rand_in(); route(bitk); step(); check_all("R6 stuck toggle locate");
    end

    // R7: neutralised stuck-toggle equals stuck-cross, others in normal mode
    for (int k = 0; k < N; k++) begin
      bitk = N'(1) << k;
      rand_in();
      sc = '0; st = bitk; fc = bitk; ft = '0; step();
      for (int i = 0; i < ROWS; i++) sav_e[i] = eout(i);
      for (int j = 0; j < COLS; j++) sav_s[j] = sout(j);
      sc = bitk; st = '0; fc = '0; step();
      for (int i = 0; i < ROWS; i++) exp_e[i] = sav_e[i];
      for (int j = 0; j < COLS; j++) exp_s[j] = sav_s[j];
      check_all("R7 neutralise equals stuck cross");
    end

    // R8 R10: square blocks forced toggle, rest forced cross
    sc = '0; st = '0;
    for (int sz = 2; sz <= 3; sz++)
      for (int r = 0; r + sz <= ROWS; r++)
        for (int c = 0; c + sz <= COLS; c++) begin
          blk = '0;
          for (int i = r; i < r + sz; i++)
            for (int j = c; j < c + sz; j++) blk[i*COLS+j] = 1'b1;
          ft = blk; fc = ~blk;
          rand_in(); cnt = $countones({wv, nv}); route(blk); step();
          check_all("R8 square block");
          check_int("R10 valid count", $countones({ev, sv}), cnt);
        end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule